// File: doc/BRIEF.md
# UART Receiver Wake-Up Control

This block decides when a receiver that software has put to sleep starts handing characters to software again. Software raises a one-cycle sleep request. From then on the block holds an inhibit output high, and the receive-full, idle and error flags elsewhere in the receiver use it to stay frozen. The block wakes the receiver by one of two rules, chosen by a method input:

- **Idle rule:** the line stays high for one whole character time.
- **Address-mark rule:** a received character arrives with its top bit set.

The block also keeps an idle-line flag for software. The flag reports a full character time of quiet line that follows a character delivered while awake.

The block watches four things: the sampled receive line, the receiver's character-complete strobe, the top data bit of that character, and a per-sample enable. There are OSR sample ticks per bit time. A character time lasts 10 bit times with 8-bit characters and 11 bit times with 9-bit characters.

Top module: `uart_rx_wake`

## Requirements
- R1: After reset, `asleep`, `flag_inhibit` and `idle_flag` are all 0.
- R2: A cycle with `sleep_req` high makes `asleep` 1 from the next cycle. While `asleep` is 1, `flag_inhibit` is 1, except as R5 allows. While `asleep` is 0, `flag_inhibit` is 0.
- R3: With `wake_method`=0 (idle rule), `asleep` returns to 0 at the clock edge that completes the L-th tick cycle with `rx_line`=1. L = OSR×10 when `len9`=0 and OSR×11 when `len9`=1. Ticks are counted from the latest cycle that had `sleep_req`, `char_done` or `rx_line`=0.
- R4: A single cycle with `rx_line`=0 restarts the idle count, so a further full L ticks are needed.
- R5: With `wake_method`=1 (address rule), a cycle that has `char_done`=1 and `char_msb`=1 while asleep clears `asleep` at the next edge. `flag_inhibit` is 0 in that cycle, so the character is delivered. A character with `char_msb`=0 keeps `asleep` and `flag_inhibit` at 1.
- R6: Under the idle rule, a character with `char_msb`=1 does not wake the receiver. Under the address rule, an idle stretch of any length does not wake it.
- R7: `idle_flag` becomes 1 at the edge that completes L idle ticks while awake, if a character has been delivered (`char_done` with `flag_inhibit`=0) since the flag was last set. `idle_clr` clears the flag. A set in the same cycle wins over `idle_clr`.
- R8: A line that stays quiet raises `idle_flag` at most once per delivered character. Without a delivered character since reset, or since the last set, it never rises.
- R9: `idle_flag` never rises while asleep. Characters that arrive while `flag_inhibit`=1 do not arm it.
- R10: `sleep_req` wins over a wake event in the same cycle.
- R11: The idle count advances only in cycles with `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-time enable, OSR per bit time |
| rx_line | input | 1 | Sampled receive line |
| len9 | input | 1 | 1 = 9-bit characters (11 bit times), 0 = 8-bit (10 bit times) |
| wake_method | input | 1 | 0 = idle rule, 1 = address-mark rule |
| sleep_req | input | 1 | One-cycle request to put the receiver to sleep |
| char_done | input | 1 | Receiver character-complete strobe |
| char_msb | input | 1 | Top data bit of the completed character |
| idle_clr | input | 1 | Clears the idle flag |
| asleep | output | 1 | Receiver sleep state |
| flag_inhibit | output | 1 | Freezes the receive flags for the current character |
| idle_flag | output | 1 | Idle-line detected |

## Verification
The idle rule is swept over both character lengths, sampling `asleep` one tick before and exactly at L. Single low cycles are placed at spaced positions inside the window, which separates a counter that restarts from one that only pauses. The bench gates ticks on alternate cycles to show that counting follows `tick` and not the clock. Under the address rule it sends characters with the top bit at 0 and at 1, alone and together with a sleep request, which separates a waking character from a non-waking one and checks the priority. The idle flag is driven through delivered, inhibited and absent characters, which tells the arming rule apart from a plain idle detector.

// File: rtl/ur_wake_pkg.sv
package ur_wake_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    typedef struct packed {
        logic done;
        logic msb;
    } char_evt_t;

    // bit times in one character, start and stop included
    function automatic int unsigned frame_bits(input logic nine_bit);
        return nine_bit ? 11 : 10;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned osr);
        return $clog2(11 * osr + 1);
    endfunction

endpackage

// File: rtl/ur_idle_timer.sv
module ur_idle_timer
    import ur_wake_pkg::*;
#(
    parameter int unsigned OSR   = 16,
    parameter int unsigned CNT_W = cnt_width(OSR)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_line,
    input  logic len9,
    input  logic restart,
    output logic idle_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             clear;

    assign limit    = CNT_W'(frame_bits(len9) * OSR);
    assign clear    = restart | ~rx_line;
    assign idle_hit = tick & ~clear & (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ur_sleep_ctl.sv
module ur_sleep_ctl
    import ur_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  wake_mode_e mode,
    input  logic       idle_hit,
    input  char_evt_t  evt,
    output logic       asleep,
    output logic       inhibit
);
    logic addr_mark;
    logic wake;

    assign addr_mark = (mode == WAKE_ADDR) & evt.done & evt.msb;
    assign wake      = ((mode == WAKE_IDLE) & idle_hit) | addr_mark;
    assign inhibit   = asleep & ~addr_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b0;
        end else if (sleep_req) begin
            asleep <= 1'b1;
        end else if (wake) begin
            asleep <= 1'b0;
        end
    end
endmodule

// File: rtl/ur_idle_flag.sv
module ur_idle_flag (
    input  logic clk,
    input  logic rst,
    input  logic idle_hit,
    input  logic asleep,
    input  logic inhibit,
    input  logic char_done,
    input  logic idle_clr,
    output logic idle_flag
);
    logic armed_q;
    logic set;

    assign set = idle_hit & armed_q & ~asleep;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            idle_flag <= 1'b0;
        end else begin
            if (char_done && !inhibit) begin
                armed_q <= 1'b1;
            end else if (set) begin
                armed_q <= 1'b0;
            end
            if (set) begin
                idle_flag <= 1'b1;
            end else if (idle_clr) begin
                idle_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import ur_wake_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_line,
    input  logic len9,
    input  logic wake_method,
    input  logic sleep_req,
    input  logic char_done,
    input  logic char_msb,
    input  logic idle_clr,
    output logic asleep,
    output logic flag_inhibit,
    output logic idle_flag
);
    localparam int unsigned CNT_W = cnt_width(OSR);

    wake_mode_e mode;
    char_evt_t  evt;
    logic       idle_hit;

    assign mode     = wake_mode_e'(wake_method);
    assign evt.done = char_done;
    assign evt.msb  = char_msb;

    ur_idle_timer #(.OSR(OSR), .CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rx_line  (rx_line),
        .len9     (len9),
        .restart  (sleep_req | char_done),
        .idle_hit (idle_hit)
    );

    ur_sleep_ctl u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .mode      (mode),
        .idle_hit  (idle_hit),
        .evt       (evt),
        .asleep    (asleep),
        .inhibit   (flag_inhibit)
    );

    ur_idle_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .idle_hit  (idle_hit),
        .asleep    (asleep),
        .inhibit   (flag_inhibit),
        .char_done (char_done),
        .idle_clr  (idle_clr),
        .idle_flag (idle_flag)
    );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
    input logic clk,
    input logic rst,
    input logic rx_line,
    input logic wake_method,
    input logic sleep_req,
    input logic char_done,
    input logic char_msb,
    input logic asleep,
    input logic flag_inhibit,
    input logic idle_flag
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!asleep && !idle_flag));

    p_sleep_sets_r2: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> asleep);

    p_awake_no_inhibit_r2: assert property (@(posedge clk) disable iff (rst)
        !asleep |-> !flag_inhibit);

    p_low_line_keeps_sleep_r4: assert property (@(posedge clk) disable iff (rst)
        (asleep && !wake_method && !rx_line) |=> asleep);

    p_addr_mark_wakes_r5: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake_method && char_done && char_msb && !sleep_req) |=> !asleep);

    p_idle_rule_ignores_mark_r6: assert property (@(posedge clk) disable iff (rst)
        (asleep && !wake_method && char_done) |=> asleep);

    p_flag_only_awake_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> $past(!asleep));
endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_line      (rx_line),
    .wake_method  (wake_method),
    .sleep_req    (sleep_req),
    .char_done    (char_done),
    .char_msb     (char_msb),
    .asleep       (asleep),
    .flag_inhibit (flag_inhibit),
    .idle_flag    (idle_flag)
);

// File: tb/sim_uart_rx_wake.sv
module sim_uart_rx_wake;
    localparam int PERIOD = 10;
    localparam int OSR    = 4;
    localparam int L8     = OSR * 10;
    localparam int L9     = OSR * 11;

    logic clk = 1'b0;
    logic rst, tick, rx_line, len9, wake_method, sleep_req, char_done, char_msb, idle_clr;
    logic asleep, flag_inhibit, idle_flag;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    uart_rx_wake #(.OSR(OSR)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line), .len9(len9),
        .wake_method(wake_method), .sleep_req(sleep_req), .char_done(char_done),
        .char_msb(char_msb), .idle_clr(idle_clr), .asleep(asleep),
        .flag_inhibit(flag_inhibit), .idle_flag(idle_flag)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        cyc();
        sleep_req = 1'b0;
    endtask

    task automatic send_char(input logic msb);
        char_done = 1'b1;
        char_msb  = msb;
        cyc();
        char_done = 1'b0;
        char_msb  = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b1; rx_line = 1'b1; len9 = 1'b0; wake_method = 1'b0;
        sleep_req = 1'b0; char_done = 1'b0; char_msb = 1'b0; idle_clr = 1'b0;
        #1;
        cyc(); cyc();
        chk("R1 asleep", asleep, 1'b0);
        chk("R1 idle_flag", idle_flag, 1'b0);
        chk("R1 inhibit", flag_inhibit, 1'b0);
        rst = 1'b0;

        // quiet line with no delivered character never raises the flag
        repeat (3 * L8) cyc();
        chk("R8 unarmed quiet", idle_flag, 1'b0);

        // idle rule window across both lengths
        for (int ln = 0; ln < 2; ln++) begin
            int lim;
            lim  = (ln == 1) ? L9 : L8;
            len9 = ln[0];
            go_sleep();
            chk("R2 asleep after request", asleep, 1'b1);
            chk("R2 inhibit while asleep", flag_inhibit, 1'b1);
            repeat (lim - 1) cyc();
            chk("R3 still asleep at L-1", asleep, 1'b1);
            cyc();
            chk("R3 awake at L", asleep, 1'b0);
            chk("R2 inhibit drops", flag_inhibit, 1'b0);
        end
        len9 = 1'b0;

        // a low cycle anywhere restarts the count
        for (int k = 0; k < L8; k += 7) begin
            go_sleep();
            repeat (k) cyc();
            rx_line = 1'b0;
            cyc();
            rx_line = 1'b1;
            repeat (L8 - 1) cyc();
            chk("R4 restart holds sleep", asleep, 1'b1);
            cyc();
            chk("R4 wake after fresh window", asleep, 1'b0);
        end

        // counting only on tick cycles
        go_sleep();
        tick = 1'b0;
        repeat (3 * L8) cyc();
        chk("R11 no tick no wake", asleep, 1'b1);
        repeat (L8 - 1) begin
            tick = 1'b1; cyc();
            tick = 1'b0; cyc();
        end
        chk("R11 L-1 ticks", asleep, 1'b1);
        tick = 1'b1;
        cyc();
        chk("R11 L ticks", asleep, 1'b0);

        // address rule
        wake_method = 1'b1;
        go_sleep();
        repeat (2 * L8) cyc();
        chk("R6 idle ignored in address rule", asleep, 1'b1);
        char_done = 1'b1; char_msb = 1'b0;
        #1;
        chk("R5 plain char inhibited", flag_inhibit, 1'b1);
        cyc();
        char_done = 1'b0;
        chk("R5 plain char keeps sleep", asleep, 1'b1);
        char_done = 1'b1; char_msb = 1'b1; sleep_req = 1'b1;
        cyc();
        char_done = 1'b0; char_msb = 1'b0; sleep_req = 1'b0;
        chk("R10 sleep request wins", asleep, 1'b1);
        char_done = 1'b1; char_msb = 1'b1;
        #1;
        chk("R5 mark char delivered", flag_inhibit, 1'b0);
        cyc();
        char_done = 1'b0; char_msb = 1'b0;
        chk("R5 mark wakes", asleep, 1'b0);
        repeat (L8 - 1) cyc();
        chk("R7 flag not yet", idle_flag, 1'b0);
        cyc();
        chk("R7 flag set after delivered char", idle_flag, 1'b1);
        idle_clr = 1'b1;
        cyc();
        idle_clr = 1'b0;
        chk("R7 flag cleared", idle_flag, 1'b0);
        repeat (3 * L8) cyc();
        chk("R8 raised only once", idle_flag, 1'b0);

        // idle rule ignores mark characters; inhibited chars do not arm
        wake_method = 1'b0;
        go_sleep();
        char_done = 1'b1; char_msb = 1'b1;
        #1;
        chk("R6 mark char inhibited in idle rule", flag_inhibit, 1'b1);
        cyc();
        char_done = 1'b0; char_msb = 1'b0;
        chk("R6 mark does not wake idle rule", asleep, 1'b1);
        repeat (L8 - 1) cyc();
        chk("R3 restart by char", asleep, 1'b1);
        cyc();
        chk("R3 wake after char window", asleep, 1'b0);
        chk("R9 no flag on waking edge", idle_flag, 1'b0);
        rx_line = 1'b0;
        cyc();
        rx_line = 1'b1;
        repeat (2 * L8) cyc();
        chk("R9 inhibited char did not arm", idle_flag, 1'b0);

        // armed, then asleep through the idle time
        send_char(1'b0);
        go_sleep();
        repeat (L8) cyc();
        chk("R9 woke by idle", asleep, 1'b0);
        chk("R9 flag blocked while asleep", idle_flag, 1'b0);

        // set beats clear in the same cycle
        send_char(1'b0);
        repeat (L8 - 1) cyc();
        idle_clr = 1'b1;
        cyc();
        idle_clr = 1'b0;
        chk("R7 set wins over clear", idle_flag, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule